// File: doc/BRIEF.md
# Handshake Control-Line Logic

This block manages the two control lines that sit beside an 8-bit data port. The first line is always an input. It raises a flag on a chosen edge. The second line is set by a 3-bit mode field. In four modes it is an edge-detecting input, with or without automatic clearing of its flag. In the other four modes it is an output: a handshake line, a one-cycle pulse, or a fixed level. A 4-bit configuration value selects the first line's edge and the second line's mode.

The block sees the data port only through access strobes. A read or write strobe, qualified by an alias bit, marks an access through the normal address or through the alternate address that performs no handshake. It returns the two flags together with the level and the output enable for the second line. The raw line levels pass through a synchroniser before any edge is detected. Timers, interrupt enables and the data path of the port belong to other blocks.

Top module: `hsk_ctrl_lines`

## Requirements
- R1: `cfg_i[0]` selects the active edge of line 1 (0 = falling, 1 = rising). `flag1_o` sets on that edge and ignores the other edge.
- R2: `cfg_i[3:1]` holds the line-2 mode. The input modes are 000 (falling), 001 (falling, independent), 010 (rising) and 011 (rising, independent). In these modes `flag2_o` sets on the selected edge of line 2 and only on that edge.
- R3: In modes 000 and 010, a normal data-port access clears `flag2_o`. In modes 001 and 011, a normal access leaves `flag2_o` set.
- R4: A flag write clears each flag whose bit in `flag_wdata_i` is 1: bit 0 for flag 1 and bit 1 for flag 2. A flag whose bit is 0 is left unchanged.
- R5: In mode 100 (handshake), a normal access drives `line2_o` low from the next cycle. The line returns high one cycle after the active edge of line 1 is detected.
- R6: In mode 101 (pulse), a normal access drives `line2_o` low for exactly one cycle, starting the cycle after the access.
- R7: Mode 110 holds `line2_o` low and mode 111 holds it high, whatever the accesses. `line2_oe_o` equals `cfg_i[3]`, and `line2_o` is high in every input mode.
- R8: An access with `acc_alias_i` = 1 changes neither flag and starts no handshake and no pulse.
- R9: A normal read or write access clears `flag1_o` on the next cycle.
- R10: A line change is seen by the flag three clock edges after it is presented. This covers the two synchroniser stages and one edge-detect register. When an edge and a clearing event fall in the same cycle, the flag ends up set.
- R11: After reset, both flags are 0, `line2_o` is 1 and both synchronisers hold the level 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 4 | Bit 0: line-1 edge; bits 3:1: line-2 mode |
| acc_rd_i | input | 1 | Data-port read strobe |
| acc_wr_i | input | 1 | Data-port write strobe |
| acc_alias_i | input | 1 | Marks the access as one through the no-handshake address |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 2 | Write-one-to-clear mask for flag 1 (bit 0) and flag 2 (bit 1) |
| line1_i | input | 1 | Raw level of line 1 |
| line2_i | input | 1 | Raw level of line 2 |
| flag1_o | output | 1 | Line-1 event flag |
| flag2_o | output | 1 | Line-2 event flag |
| line2_o | output | 1 | Drive level for line 2 |
| line2_oe_o | output | 1 | Output enable for line 2 |

## Verification
The bench sweeps every combination of edge polarity and line direction for both lines. A design that decoded the polarity bit the wrong way round would raise flags on the wrong edge. The bench checks that the flag stays low two edges after a change and is high on the third. A synchroniser that was one stage too short or too long fails here. It places a clearing access in the same cycle as a detected edge, where a design that let the clear win would lose the event. It also uses alias accesses in the handshake and pulse modes, where a design that ignored the alias bit would clear a flag or drop `line2_o`.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
   localparam int CFG_W  = 4;
   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      L2_IN_FALL      = 3'b000,
      L2_IN_FALL_IND  = 3'b001,
      L2_IN_RISE      = 3'b010,
      L2_IN_RISE_IND  = 3'b011,
      L2_OUT_HSHAKE   = 3'b100,
      L2_OUT_PULSE    = 3'b101,
      L2_OUT_LOW      = 3'b110,
      L2_OUT_HIGH     = 3'b111
   } l2_mode_e;
endpackage

// File: rtl/hsk_line_sync.sv
module hsk_line_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic rise_o,
   output logic fall_o
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("hsk_line_sync: STAGES must be at least 2");
   end

   logic [LAST:0] chain_q;
   logic          prev_q;

   for (genvar i = 0; i <= LAST; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RST_LVL;
            else        chain_q[0] <= raw_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= RST_LVL;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_LVL;
      else        prev_q <= chain_q[LAST];
   end

   assign rise_o =  chain_q[LAST] & ~prev_q;
   assign fall_o = ~chain_q[LAST] &  prev_q;
endmodule

// File: rtl/hsk_event_flag.sv
module hsk_event_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end

   // R10: a detected edge wins over any clear in the same cycle
   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
endmodule

// File: rtl/hsk_line_drive.sv
module hsk_line_drive
   import hsk_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  l2_mode_e mode_i,
   input  logic     acc_i,
   input  logic     release_i,
   output logic     out_o,
   output logic     oe_o
);
   logic hs_q;
   logic pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      hs_q <= 1'b1;
      else if (mode_i != L2_OUT_HSHAKE) hs_q <= 1'b1;
      else if (acc_i)                  hs_q <= 1'b0;
      else if (release_i)              hs_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= acc_i && (mode_i == L2_OUT_PULSE);
   end

   always_comb begin
      case (mode_i)
         L2_OUT_HSHAKE: out_o = hs_q;
         L2_OUT_PULSE:  out_o = ~pulse_q;
         L2_OUT_LOW:    out_o = 1'b0;
         default:       out_o = 1'b1;
      endcase
   end

   assign oe_o = mode_i[MODE_W-1];

   // R5: handshake access pulls the line low on the following cycle
   assert_hs_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == L2_OUT_HSHAKE && acc_i) |=> (mode_i != L2_OUT_HSHAKE || !out_o));

   // R6: a pulse low never lasts longer than one cycle without a new access
   assert_pulse_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == L2_OUT_PULSE && !out_o && !acc_i) |=> (mode_i != L2_OUT_PULSE || out_o));
endmodule

// File: rtl/hsk_ctrl_lines.sv
module hsk_ctrl_lines
   import hsk_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg_i,
   input  logic             acc_rd_i,
   input  logic             acc_wr_i,
   input  logic             acc_alias_i,
   input  logic             flag_wr_i,
   input  logic [1:0]       flag_wdata_i,
   input  logic             line1_i,
   input  logic             line2_i,
   output logic             flag1_o,
   output logic             flag2_o,
   output logic             line2_o,
   output logic             line2_oe_o
);
   localparam int NLINES = 2;

   if (CFG_W != MODE_W + 1) begin : g_bad_cfg
      $error("hsk_ctrl_lines: configuration width mismatch");
   end

   logic [NLINES-1:0] raw, rise, fall;
   assign raw = {line2_i, line1_i};

   for (genvar g = 0; g < NLINES; g++) begin : g_sync
      hsk_line_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw_i  (raw[g]),
         .rise_o (rise[g]),
         .fall_o (fall[g])
      );
   end

   l2_mode_e mode;
   logic     norm_acc;
   logic     edge1, edge2;
   logic     l2_input, l2_indep;
   logic     set1, clr1, set2, clr2;

   assign mode     = l2_mode_e'(cfg_i[CFG_W-1:1]);
   assign norm_acc = (acc_rd_i | acc_wr_i) & ~acc_alias_i;
   assign l2_input = ~cfg_i[CFG_W-1];
   assign l2_indep = cfg_i[1];
   assign edge1    = cfg_i[0] ? rise[0] : fall[0];
   assign edge2    = l2_input & (cfg_i[2] ? rise[1] : fall[1]);

   assign set1 = edge1;
   assign clr1 = norm_acc | (flag_wr_i & flag_wdata_i[0]);
   assign set2 = edge2;
   assign clr2 = (norm_acc & l2_input & ~l2_indep) | (flag_wr_i & flag_wdata_i[1]);

   hsk_event_flag u_flag1 (
      .clk(clk), .rst_n(rst_n), .set_i(set1), .clr_i(clr1), .flag_o(flag1_o));

   hsk_event_flag u_flag2 (
      .clk(clk), .rst_n(rst_n), .set_i(set2), .clr_i(clr2), .flag_o(flag2_o));

   hsk_line_drive u_drive (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (mode),
      .acc_i     (norm_acc),
      .release_i (edge1),
      .out_o     (line2_o),
      .oe_o      (line2_oe_o)
   );

   // R8: alias accesses never clear a flag
   assert_alias_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((acc_rd_i | acc_wr_i) && acc_alias_i && !flag_wr_i) |=> (!$fell(flag1_o) && !$fell(flag2_o)));

   // R3: independent input modes keep flag 2 through normal accesses
   assert_indep_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (flag2_o && !cfg_i[3] && cfg_i[1] && !(flag_wr_i && flag_wdata_i[1])) |=> flag2_o);
endmodule

// File: tb/hsk_ctrl_lines_bench.sv
module hsk_ctrl_lines_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] cfg = 4'b0000;
   logic       acc_rd = 1'b0, acc_wr = 1'b0, acc_alias = 1'b0;
   logic       flag_wr = 1'b0;
   logic [1:0] flag_wdata = 2'b00;
   logic       l1 = 1'b1, l2 = 1'b1;
   logic       flag1, flag2, line2, line2_oe;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   hsk_ctrl_lines u_hsk_ctrl_lines (
      .clk(clk), .rst_n(rst_n), .cfg_i(cfg),
      .acc_rd_i(acc_rd), .acc_wr_i(acc_wr), .acc_alias_i(acc_alias),
      .flag_wr_i(flag_wr), .flag_wdata_i(flag_wdata),
      .line1_i(l1), .line2_i(l2),
      .flag1_o(flag1), .flag2_o(flag2), .line2_o(line2), .line2_oe_o(line2_oe));

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic access(input logic rd, input logic alias_b);
      acc_rd = rd; acc_wr = ~rd; acc_alias = alias_b;
      tick();
      acc_rd = 0; acc_wr = 0; acc_alias = 0;
   endtask

   task automatic clear_flags(input logic [1:0] m);
      flag_wr = 1; flag_wdata = m;
      tick();
      flag_wr = 0; flag_wdata = 0;
   endtask

   task automatic settle(input logic v1, input logic v2);
      l1 = v1; l2 = v2;
      tick(5);
      clear_flags(2'b11);
   endtask

   initial begin
      #200000;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1;
      tick();
      // R11 reset state
      chk("R11 flag1", flag1, 0);
      chk("R11 flag2", flag2, 0);
      chk("R11 line2", line2, 1);
      chk("R7 oe input mode", line2_oe, 0);

      // R1 / R10: line-1 edge polarity sweep
      for (int pol = 0; pol < 2; pol++)
         for (int dir = 0; dir < 2; dir++) begin
            cfg = {3'b000, pol[0]};
            settle(~dir[0], l2);
            l1 = dir[0];
            tick(2);
            chk("R10 latency", flag1, 0);
            tick();
            chk("R1 edge", flag1, pol == dir);
         end

      // R9: normal read and write clear flag 1
      access(1, 0);
      chk("R9 read clear", flag1, 0);
      settle(0, l2); l1 = 1; tick(3);
      chk("R1 set again", flag1, 1);
      access(0, 0);
      chk("R9 write clear", flag1, 0);

      // R4: mask-selective clearing of flag 1
      settle(0, l2); l1 = 1; tick(3);
      clear_flags(2'b10);
      chk("R4 flag1 kept", flag1, 1);
      clear_flags(2'b01);
      chk("R4 flag1 cleared", flag1, 0);

      // R2 / R3 / R4: line-2 input modes sweep
      for (int m = 0; m < 4; m++)
         for (int dir = 0; dir < 2; dir++) begin
            logic exp;
            cfg = {m[2:0], 1'b1};
            settle(l1, ~dir[0]);
            l2 = dir[0];
            tick(3);
            exp = (dir[0] == m[1]);
            chk("R2 line2 edge", flag2, exp);
            chk("R7 oe input", line2_oe, 0);
            chk("R7 level input", line2, 1);
            if (exp) begin
               access(1, 0);
               chk("R3 access clear", flag2, m[0]);
               if (m[0]) begin
                  clear_flags(2'b01);
                  chk("R4 flag2 kept", flag2, 1);
                  clear_flags(2'b10);
                  chk("R4 flag2 cleared", flag2, 0);
               end
            end
         end

      // R10: edge and clearing access in the same cycle
      cfg = 4'b0001;
      settle(0, l2);
      l1 = 1;
      tick(2);
      acc_rd = 1; tick(); acc_rd = 0;
      chk("R10 set wins", flag1, 1);
      access(1, 0);
      chk("R9 clear after", flag1, 0);

      // R5: handshake
      cfg = 4'b1001;
      settle(0, l2);
      chk("R5 idle high", line2, 1);
      chk("R7 oe output", line2_oe, 1);
      access(1, 0);
      chk("R5 low after access", line2, 0);
      tick(3);
      chk("R5 stays low", line2, 0);
      l1 = 1;
      tick(2);
      chk("R5 low before edge seen", line2, 0);
      tick();
      chk("R5 released", line2, 1);

      // R6: pulse
      cfg = 4'b1010;
      tick();
      chk("R6 idle", line2, 1);
      access(0, 0);
      chk("R6 low", line2, 0);
      tick();
      chk("R6 back high", line2, 1);
      access(1, 0);
      chk("R6 low read", line2, 0);
      tick();
      chk("R6 one cycle", line2, 1);

      // R7: fixed levels
      cfg = 4'b1100; tick();
      chk("R7 low", line2, 0);
      access(1, 0); tick();
      chk("R7 low held", line2, 0);
      cfg = 4'b1110; tick();
      chk("R7 high", line2, 1);
      access(0, 0);
      chk("R7 high held", line2, 1);

      // R8: alias accesses
      cfg = 4'b0001;
      settle(0, 1);
      l1 = 1; l2 = 0;
      tick(3);
      chk("R8 flag1 set", flag1, 1);
      chk("R8 flag2 set", flag2, 1);
      access(1, 1);
      access(0, 1);
      chk("R8 flag1 kept", flag1, 1);
      chk("R8 flag2 kept", flag2, 1);
      cfg = 4'b1001; tick();
      access(1, 1);
      chk("R8 no handshake", line2, 1);
      cfg = 4'b1011; tick();
      access(0, 1);
      chk("R8 no pulse", line2, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule